// File: doc/BRIEF.md
# Floating-Point Minimum Selector with Selectable Special-Case Handling

This block takes two floating-point operands and returns the smaller one. It works purely combinationally, so the result follows the inputs in the same cycle. A two-bit format code picks the operand width: half, single or double precision. The narrower formats sit in the low bits of the 64-bit operand buses. The first operand is `op_a` and the second is `op_b`. The order matters whenever the result depends on which operand came first.

Two mode bits control the special cases. With `alt_mode` low the block follows standard minimum semantics:

- A negative zero sorts below a positive zero.
- A NaN input produces a quiet NaN, chosen by a fixed priority.
- When `dn_mode` is high, a NaN input instead produces a single canonical NaN.

With `alt_mode` high, a pair of zeros or any NaN input makes the block return the second operand untouched. The `dn_mode` bit then has no effect.

Rounding is never needed, because the result is always one of the inputs or a NaN built from them. Exception flags and denormal flushing are not part of this block.

Top module: `fpmin_unit`

## Requirements
- R1: When no operand is a NaN and the zero rule of R5 does not apply, the result is the operand that is smaller by sign and magnitude, returned bit for bit unchanged. This holds for infinities and subnormals too.
- R2: With `alt_mode` = 0, negative zero orders below positive zero, so a +0/-0 pair gives -0 in either operand order.
- R3: With `alt_mode` = 0 and `dn_mode` = 0, a NaN input gives the first match from this priority list, and the quiet bit (the top fraction bit) of the chosen value is forced to 1:
  1. `op_a` if it is signalling;
  2. otherwise `op_b` if it is signalling;
  3. otherwise `op_a` if it is a NaN;
  4. otherwise `op_b`.
- R4: With `alt_mode` = 0 and `dn_mode` = 1, a NaN input gives the default NaN: sign 0, exponent all ones, top fraction bit 1, all other fraction bits 0. This is 0x7E00 for half, 0x7FC00000 for single and 0x7FF8000000000000 for double.
- R5: With `alt_mode` = 1 and both operands zero, of any sign, the result is `op_b`.
- R6: With `alt_mode` = 1 and either operand a NaN, the result is `op_b` unchanged, whatever the value of `dn_mode`.
- R7: The format codes and field positions are:

  | `fmt` | Format | Operand bits | Sign bit | Exponent bits | Fraction bits |
  |-------|--------|--------------|----------|---------------|---------------|
  | 2'b01 | half   | [15:0]       | 15       | [14:10]       | [9:0]         |
  | 2'b10 | single | [31:0]       | 31       | [30:23]       | [22:0]        |
  | 2'b11 | double | [63:0]       | 63       | [62:52]       | [51:0]        |

  Operand bits above the selected width are ignored, and result bits above it are 0.
- R8: Format code 2'b00 is reserved and gives a result of all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 64 | First operand, right-aligned for narrow formats |
| op_b | input | 64 | Second operand, right-aligned for narrow formats |
| fmt | input | 2 | Format code: 01 half, 10 single, 11 double, 00 reserved |
| alt_mode | input | 1 | Alternate special-case handling: zero pairs and NaNs return `op_b` |
| dn_mode | input | 1 | Replace NaN results with the default NaN when `alt_mode` is 0 |
| result | output | 64 | Minimum, right-aligned, upper bits zero |

## Verification
The block holds no state, so a fault in its classification or its selection shows at `result` in the same cycle the operands are applied. Misdetecting a zero or a NaN changes which operand is returned, or replaces a number with a NaN pattern. A wrong field position for one format shows up only under that format code, so each format's NaN, zero and magnitude cases are applied separately. Priority faults in NaN propagation appear only when both operands are NaNs of different kinds, so those pairs are applied in both orders.

// File: rtl/fpmin_pkg.sv
package fpmin_pkg;

  localparam int DATA_W      = 64;
  localparam int MAG_W       = DATA_W - 1;
  localparam int NUM_FMT     = 4;
  localparam int HALF_EXP_W  = 5;
  localparam int HALF_FRAC_W = 10;
  localparam int SGL_EXP_W   = 8;
  localparam int SGL_FRAC_W  = 23;
  localparam int DBL_EXP_W   = 11;
  localparam int DBL_FRAC_W  = 52;

  typedef enum logic [1:0] {
    FMT_RSVD   = 2'd0,
    FMT_HALF   = 2'd1,
    FMT_SINGLE = 2'd2,
    FMT_DOUBLE = 2'd3
  } fmt_e;

  typedef struct packed {
    logic              sign;
    logic              is_zero;
    logic              is_nan;
    logic              is_snan;
    logic [MAG_W-1:0]  mag;
    logic [DATA_W-1:0] bits;
  } fp_class_t;

  function automatic int exp_w(input logic [1:0] f);
    case (f)
      2'd1:    return HALF_EXP_W;
      2'd2:    return SGL_EXP_W;
      2'd3:    return DBL_EXP_W;
      default: return 0;
    endcase
  endfunction

  function automatic int frac_w(input logic [1:0] f);
    case (f)
      2'd1:    return HALF_FRAC_W;
      2'd2:    return SGL_FRAC_W;
      2'd3:    return DBL_FRAC_W;
      default: return 0;
    endcase
  endfunction

  function automatic int sign_pos(input logic [1:0] f);
    return exp_w(f) + frac_w(f);
  endfunction

  function automatic logic [DATA_W-1:0] width_mask(input logic [1:0] f);
    int w;
    w = (f == 2'd0) ? 0 : sign_pos(f) + 1;
    if (w == 0) return '0;
    if (w >= DATA_W) return '1;
    return (DATA_W'(1) << w) - DATA_W'(1);
  endfunction

  function automatic logic [DATA_W-1:0] quiet_mask(input logic [1:0] f);
    if (f == 2'd0) return '0;
    return DATA_W'(1) << (frac_w(f) - 1);
  endfunction

  function automatic logic [DATA_W-1:0] exp_field_mask(input logic [1:0] f);
    if (f == 2'd0) return '0;
    return ((DATA_W'(1) << exp_w(f)) - DATA_W'(1)) << frac_w(f);
  endfunction

  function automatic logic [DATA_W-1:0] default_nan(input logic [1:0] f);
    return exp_field_mask(f) | quiet_mask(f);
  endfunction

endpackage

// File: rtl/fpmin_classify.sv
module fpmin_classify
  import fpmin_pkg::*;
(
  input  logic [DATA_W-1:0] raw,
  input  fmt_e              fmt,
  output fp_class_t         cls
);

  for (genvar k = 1; k < NUM_FMT; k++) begin : g_fmt
    localparam int EW = exp_w(2'(k));
    localparam int FW = frac_w(2'(k));
    logic [EW-1:0] expo;
    logic [FW-1:0] frac;
    fp_class_t     c;

    assign expo = raw[FW +: EW];
    assign frac = raw[FW-1:0];

    always_comb begin
      c                  = '0;
      c.sign             = raw[EW+FW];
      c.is_zero          = (expo == '0) && (frac == '0);
      c.is_nan           = (&expo) && (frac != '0);
      c.is_snan          = (&expo) && (frac != '0) && !frac[FW-1];
      c.mag[EW+FW-1:0]   = raw[EW+FW-1:0];
      c.bits[EW+FW:0]    = raw[EW+FW:0];
    end
  end

  always_comb begin
    case (fmt)
      FMT_HALF:   cls = g_fmt[1].c;
      FMT_SINGLE: cls = g_fmt[2].c;
      FMT_DOUBLE: cls = g_fmt[3].c;
      default:    cls = '0;
    endcase
  end

endmodule

// File: rtl/fpmin_order.sv
module fpmin_order
  import fpmin_pkg::*;
(
  input  logic             a_sign,
  input  logic [MAG_W-1:0] a_mag,
  input  logic             b_sign,
  input  logic [MAG_W-1:0] b_mag,
  output logic             a_first
);

  logic mag_le;
  logic mag_ge;

  assign mag_le = (a_mag <= b_mag);
  assign mag_ge = (a_mag >= b_mag);

  // Differing signs: the negative one is smaller (covers -0 vs +0).
  // Both negative: larger magnitude is smaller.
  always_comb begin
    if (a_sign != b_sign) a_first = a_sign;
    else if (a_sign)      a_first = mag_ge;
    else                  a_first = mag_le;
  end

endmodule

// File: rtl/fpmin_nan_pick.sv
module fpmin_nan_pick
  import fpmin_pkg::*;
(
  input  fmt_e              fmt,
  input  logic              dn_mode,
  input  logic              a_nan,
  input  logic              a_snan,
  input  logic              b_snan,
  input  logic [DATA_W-1:0] a_bits,
  input  logic [DATA_W-1:0] b_bits,
  output logic [DATA_W-1:0] nan_bits
);

  logic [DATA_W-1:0] qbit;
  logic [DATA_W-1:0] canon;

  assign qbit  = quiet_mask(fmt);
  assign canon = default_nan(fmt);

  always_comb begin
    if (dn_mode)     nan_bits = canon;
    else if (a_snan) nan_bits = a_bits | qbit;
    else if (b_snan) nan_bits = b_bits | qbit;
    else if (a_nan)  nan_bits = a_bits;
    else             nan_bits = b_bits;
  end

endmodule

// File: rtl/fpmin_unit.sv
module fpmin_unit
  import fpmin_pkg::*;
(
  input  logic [63:0] op_a,
  input  logic [63:0] op_b,
  input  logic [1:0]  fmt,
  input  logic        alt_mode,
  input  logic        dn_mode,
  output logic [63:0] result
);

  localparam int NUM_OPS = 2;

  fmt_e              fmt_q;
  logic [DATA_W-1:0] ops [NUM_OPS];
  fp_class_t         cls [NUM_OPS];
  logic              fmt_valid;
  logic              any_nan;
  logic              both_zero;
  logic              alt_take_b;
  logic              a_first;
  logic [DATA_W-1:0] nan_bits;

  assign fmt_q  = fmt_e'(fmt);
  assign ops[0] = op_a;
  assign ops[1] = op_b;

  for (genvar i = 0; i < NUM_OPS; i++) begin : g_op
    fpmin_classify u_cls (
      .raw (ops[i]),
      .fmt (fmt_q),
      .cls (cls[i])
    );
  end

  fpmin_order u_order (
    .a_sign  (cls[0].sign),
    .a_mag   (cls[0].mag),
    .b_sign  (cls[1].sign),
    .b_mag   (cls[1].mag),
    .a_first (a_first)
  );

  fpmin_nan_pick u_nan (
    .fmt      (fmt_q),
    .dn_mode  (dn_mode),
    .a_nan    (cls[0].is_nan),
    .a_snan   (cls[0].is_snan),
    .b_snan   (cls[1].is_snan),
    .a_bits   (cls[0].bits),
    .b_bits   (cls[1].bits),
    .nan_bits (nan_bits)
  );

  assign fmt_valid  = (fmt_q != FMT_RSVD);
  assign any_nan    = cls[0].is_nan | cls[1].is_nan;
  assign both_zero  = cls[0].is_zero & cls[1].is_zero;
  assign alt_take_b = alt_mode & (any_nan | both_zero);

  always_comb begin
    if (!fmt_valid)      result = '0;
    else if (alt_take_b) result = cls[1].bits;
    else if (any_nan)    result = nan_bits;
    else if (a_first)    result = cls[0].bits;
    else                 result = cls[1].bits;
  end

endmodule

// File: rtl/fpmin_chk.sv
module fpmin_chk
  import fpmin_pkg::*;
(
  input logic [63:0] op_a,
  input logic [63:0] op_b,
  input logic [1:0]  fmt,
  input logic        alt_mode,
  input logic        dn_mode,
  input logic [63:0] result,
  input logic        any_nan,
  input logic        both_zero,
  input logic        alt_take_b
);

  logic [63:0] wm;
  logic [63:0] a_m;
  logic [63:0] b_m;
  logic        known;

  assign wm    = width_mask(fmt);
  assign a_m   = op_a & wm;
  assign b_m   = op_b & wm;
  assign known = !$isunknown({op_a, op_b, fmt, alt_mode, dn_mode, result,
                              any_nan, both_zero, alt_take_b});

  always_comb begin
    if (known) begin
      if (fmt == 2'd0)
        AST_RSVD_ZERO: assert (result == '0); // R8
      AST_UPPER_CLEAR: assert ((result & ~wm) == '0); // R7
      if (fmt != 2'd0 && alt_take_b)
        AST_ALT_SECOND: assert (result == b_m); // R6
      if (fmt != 2'd0 && !alt_mode && dn_mode && any_nan)
        AST_DEFAULT_NAN: assert (result == default_nan(fmt)); // R4
      if (fmt != 2'd0 && !alt_mode && !dn_mode && any_nan)
        AST_QUIET_OUT: assert (((result & exp_field_mask(fmt)) == exp_field_mask(fmt)) &&
                               ((result & quiet_mask(fmt)) != '0)); // R3
      if (fmt != 2'd0 && !any_nan && !alt_take_b)
        AST_PICK_OPERAND: assert (result == a_m || result == b_m); // R1
      if (fmt != 2'd0 && !alt_mode && both_zero)
        AST_ZERO_ORDER: assert (result[sign_pos(fmt)] ==
                                (op_a[sign_pos(fmt)] | op_b[sign_pos(fmt)])); // R2
      if (fmt != 2'd0 && alt_mode && both_zero)
        AST_ALT_ZERO: assert (result == b_m); // R5
    end
  end

endmodule

bind fpmin_unit fpmin_chk u_chk (
  .op_a       (op_a),
  .op_b       (op_b),
  .fmt        (fmt),
  .alt_mode   (alt_mode),
  .dn_mode    (dn_mode),
  .result     (result),
  .any_nan    (any_nan),
  .both_zero  (both_zero),
  .alt_take_b (alt_take_b)
);

// File: tb/sim_fpmin_unit.sv
module sim_fpmin_unit;

  localparam logic [1:0] H = 2'b01;
  localparam logic [1:0] S = 2'b10;
  localparam logic [1:0] D = 2'b11;

  logic        clk = 1'b0;
  logic [63:0] op_a = '0;
  logic [63:0] op_b = '0;
  logic [1:0]  fmt = 2'b00;
  logic        alt_mode = 1'b0;
  logic        dn_mode = 1'b0;
  logic [63:0] result;
  int          checks = 0;
  int          errors = 0;
  bit          done = 0;

  always #10 clk = ~clk;

  fpmin_unit u0 (
    .op_a     (op_a),
    .op_b     (op_b),
    .fmt      (fmt),
    .alt_mode (alt_mode),
    .dn_mode  (dn_mode),
    .result   (result)
  );

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic apply(input logic [63:0] a, input logic [63:0] b, input logic [1:0] f,
                       input logic alt, input logic dn);
    @(negedge clk);
    op_a = a; op_b = b; fmt = f; alt_mode = alt; dn_mode = dn;
    #2;
  endtask

  task automatic t_reset;
    #3;
    check("R8 idle", result, 64'h0);
  endtask

  task automatic t_ordinary;
    apply(64'h3F800000, 64'h40000000, S, 0, 0); check("R1 1<2", result, 64'h3F800000);
    apply(64'hBF800000, 64'hC0000000, S, 0, 0); check("R1 -2<-1", result, 64'hC0000000);
    apply(64'h0002, 64'h0001, H, 0, 0);          check("R1 subnormal", result, 64'h0001);
    apply(64'h7C00, 64'h7BFF, H, 0, 0);          check("R1 inf vs max", result, 64'h7BFF);
    apply(64'h3FF0000000000000, 64'hFFF0000000000000, D, 1, 0);
    check("R1 -inf", result, 64'hFFF0000000000000);
    for (int i = 0; i < 6; i++) begin
      logic [63:0] x, y;
      x = $realtobits(1.5 * (i - 3) + 0.25);
      y = $realtobits(-0.75 * (i - 2) - 0.5);
      apply(x, y, D, 0, 0);
      check("R1 double sweep", result, ($bitstoreal(x) < $bitstoreal(y)) ? x : y);
    end
  endtask

  task automatic t_signed_zero;
    apply(64'h00000000, 64'h80000000, S, 0, 0); check("R2 +0,-0", result, 64'h80000000);
    apply(64'h80000000, 64'h00000000, S, 0, 0); check("R2 -0,+0", result, 64'h80000000);
    apply(64'h0000, 64'h8000, H, 0, 1);         check("R2 half", result, 64'h8000);
  endtask

  task automatic t_nan_propagate;
    apply(64'h7F800001, 64'h7FC00005, S, 0, 0); check("R3 a sNaN", result, 64'h7FC00001);
    apply(64'h7FC00002, 64'h7F800003, S, 0, 0); check("R3 b sNaN over a qNaN", result, 64'h7FC00003);
    apply(64'hFFC00007, 64'h7FC00009, S, 0, 0); check("R3 a qNaN", result, 64'hFFC00007);
    apply(64'h3C00, 64'h7D00, H, 0, 0);         check("R3 half b sNaN", result, 64'h7F00);
    apply(64'h3FF0000000000000, 64'hFFF8000000000001, D, 0, 0);
    check("R3 double b qNaN", result, 64'hFFF8000000000001);
  endtask

  task automatic t_default_nan;
    apply(64'h7F800001, 64'h3F800000, S, 0, 1); check("R4 single", result, 64'h7FC00000);
    apply(64'h3C00, 64'hFE01, H, 0, 1);         check("R4 half", result, 64'h7E00);
    apply(64'hFFF0000000000001, 64'h0, D, 0, 1);
    check("R4 double", result, 64'h7FF8000000000000);
  endtask

  task automatic t_alt_zero;
    apply(64'h80000000, 64'h00000000, S, 1, 0); check("R5 -0,+0", result, 64'h00000000);
    apply(64'h00000000, 64'h80000000, S, 1, 0); check("R5 +0,-0", result, 64'h80000000);
    apply(64'h8000, 64'h0000, H, 1, 1);         check("R5 half", result, 64'h0000);
  endtask

  task automatic t_alt_nan;
    apply(64'h7F800001, 64'h3F800000, S, 1, 0); check("R6 a NaN", result, 64'h3F800000);
    apply(64'h3F800000, 64'hFF800001, S, 1, 1); check("R6 b sNaN kept", result, 64'hFF800001);
    apply(64'h7FF8000000000000, 64'hC000000000000000, D, 1, 1);
    check("R6 double", result, 64'hC000000000000000);
  endtask

  task automatic t_width;
    apply(64'hDEADBEEF_3F800000, 64'h12345678_40000000, S, 0, 0);
    check("R7 upper ignored", result, 64'h00000000_3F800000);
    apply(64'hFFFFFFFF_FFFF0001, 64'h00000000_00000002, H, 0, 0);
    check("R7 half upper ignored", result, 64'h0001);
    apply(64'h00000000_7F800001, 64'h0, H, 0, 0);
    check("R7 half field position", result, 64'h0);
  endtask

  task automatic t_reserved;
    apply(64'h3F800000, 64'h40000000, 2'b00, 0, 0); check("R8 reserved", result, 64'h0);
    apply(64'h7F800001, 64'h1, 2'b00, 1, 1);        check("R8 reserved alt", result, 64'h0);
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    t_reset();
    t_ordinary();
    t_signed_zero();
    t_nan_propagate();
    t_default_nan();
    t_alt_zero();
    t_alt_nan();
    t_width();
    t_reserved();
    done = 1;
    finish_run();
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

endmodule